// File: doc/BRIEF.md
# Dual-Datapath FP32/INT32 Issue Stage

This block is the issue stage of one processing partition. A single scheduler feeds it warp instructions through a small in-order ready queue. Each instruction is tagged FP32 or INT32 and covers a 32-thread warp. Every cycle the stage takes up to two of these instructions and steers them onto two 16-lane execution datapaths.

The two datapaths are not alike. Datapath A executes FP32 work only. Datapath B executes either FP32 or INT32 work, and a single instruction occupies it at a time. A 32-thread instruction on a 16-lane datapath holds that datapath for two consecutive cycles. Instructions that cannot be placed stay in the queue in arrival order.

The queue is scanned oldest-first. A younger entry may overtake an older one only when the older entry fits no free datapath. Every issue is reported on a per-datapath port with the instruction's tag. The execution itself is represented by a fixed-latency stub that returns the tag after a set delay.

Top module: `dual_issue_unit`

## Requirements
- R1: In the first cycle after synchronous reset, neither issue port nor completion port is valid, the queue is empty (`in_rdy` = 1), and both datapaths are free.
- R2: An instruction presented with `in_vld` = 1 while `in_rdy` = 1 enters the queue at that clock edge. `in_rdy` is 0 exactly when the queue holds DEPTH entries, and an instruction offered then is not taken.
- R3: Datapath A (`iss_a_*`) receives only FP32 instructions (`in_int` = 0).
- R4: Datapath B (`iss_b_*`) receives at most one instruction per cycle, either FP32 or INT32. `iss_b_int` gives its kind: 1 for INT32, 0 for FP32.
- R5: A datapath that issued in cycle t receives nothing in cycle t+1. It is free again in cycle t+2, because a 32-thread warp on 16 lanes needs two cycles.
- R6: The oldest queued instruction that fits a free datapath issues first. A younger instruction issues ahead of an older one only if the older one fits no free datapath in that cycle.
- R7: When FP32 is placed and datapath A is free, FP32 goes to A. So when both datapaths are free and the oldest candidates are one INT32 and one FP32, INT32 goes to B and FP32 goes to A.
- R8: Up to two instructions issue per cycle. An instruction that enters the queue at clock edge k, with a free datapath it fits, is reported on the issue port right after edge k+1.
- R9: Each issue report carries the instruction's own tag on the port of the datapath it was sent to.
- R10: A completion (`done_a_*` / `done_b_*`) appears exactly LAT cycles after the matching issue, on the same datapath and with the same tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Scheduler offers an instruction |
| in_int | input | 1 | Kind of the offered instruction: 1 = INT32, 0 = FP32 |
| in_tag | input | TAG_W | Tag of the offered instruction |
| in_rdy | output | 1 | Queue has a free slot |
| iss_a_vld | output | 1 | Instruction issued to datapath A (FP32 only) |
| iss_a_tag | output | TAG_W | Tag issued to datapath A |
| iss_b_vld | output | 1 | Instruction issued to datapath B |
| iss_b_int | output | 1 | Kind issued to datapath B: 1 = INT32 |
| iss_b_tag | output | TAG_W | Tag issued to datapath B |
| done_a_vld | output | 1 | Datapath A stub completes an instruction |
| done_a_tag | output | TAG_W | Tag completing on datapath A |
| done_b_vld | output | 1 | Datapath B stub completes an instruction |
| done_b_tag | output | TAG_W | Tag completing on datapath B |

## Verification
The bench builds the block with DEPTH = 4, TAG_W = 4 and LAT = 3. With only four slots, a burst of INT32 work fills the queue within a few cycles: INT32 can drain through datapath B alone, at one instruction every two cycles. This brings the `in_rdy` backpressure edge and the overtaking of INT32 entries by younger FP32 entries within reach. Pure FP32 streams, alternating mixes and random gaps exercise dual issue, port preference and the two-cycle occupancy. The short latency keeps completions overlapping with new issues.

// File: rtl/ius_pkg.sv
package ius_pkg;

  typedef enum logic {
    OP_FP  = 1'b0,
    OP_INT = 1'b1
  } op_kind_e;

  // cycles a warp of `warp` threads holds a datapath of `lanes` lanes
  function automatic int occ_cycles(input int warp, input int lanes);
    return (warp + lanes - 1) / lanes;
  endfunction

endpackage

// File: rtl/ius_ready_queue.sv
module ius_ready_queue #(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        push_vld,
  input  logic                        push_int,
  input  logic [TAG_W-1:0]            push_tag,
  input  logic [DEPTH-1:0]            pop_mask,
  output logic [DEPTH-1:0]            ent_vld,
  output logic [DEPTH-1:0]            ent_int,
  output logic [DEPTH-1:0][TAG_W-1:0] ent_tag,
  output logic                        full
);

  logic [DEPTH-1:0]            n_vld;
  logic [DEPTH-1:0]            n_int;
  logic [DEPTH-1:0][TAG_W-1:0] n_tag;
  int                          wr;

  assign full = ent_vld[DEPTH-1];

  // survivors slide toward slot 0 keeping age order; a new entry lands behind them
  always_comb begin
    n_vld = '0;
    n_int = '0;
    n_tag = '0;
    wr    = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ent_vld[i] && !pop_mask[i]) begin
        for (int k = 0; k < DEPTH; k++) begin
          if (k == wr) begin
            n_vld[k] = 1'b1;
            n_int[k] = ent_int[i];
            n_tag[k] = ent_tag[i];
          end
        end
        wr = wr + 1;
      end
    end
    if (push_vld && !full) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (k == wr) begin
          n_vld[k] = 1'b1;
          n_int[k] = push_int;
          n_tag[k] = push_tag;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ent_vld <= '0;
      ent_int <= '0;
      ent_tag <= '0;
    end else begin
      ent_vld <= n_vld;
      ent_int <= n_int;
      ent_tag <= n_tag;
    end
  end

endmodule

// File: rtl/ius_picker.sv
module ius_picker
  import ius_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic [DEPTH-1:0] ent_vld,
  input  logic [DEPTH-1:0] ent_int,
  input  logic             free_a,
  input  logic             free_b,
  output logic [DEPTH-1:0] a_sel,
  output logic [DEPTH-1:0] b_sel
);

  logic [DEPTH-1:0] first;
  logic [DEPTH-1:0] second;
  logic             f0;
  logic             f1;
  logic             seen;
  logic             first_int;
  logic             first_to_b;
  logic             rem_a;
  logic             rem_b;

  always_comb begin
    // oldest entry that fits any free datapath
    first     = '0;
    f0        = 1'b0;
    first_int = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!f0 && ent_vld[i] &&
          ((op_kind_e'(ent_int[i]) == OP_INT) ? free_b : (free_a || free_b))) begin
        f0        = 1'b1;
        first[i]  = 1'b1;
        first_int = ent_int[i];
      end
    end
    // integer work must use B; float work prefers A
    first_to_b = first_int || !free_a;
    rem_a      = f0 && first_to_b && free_a;
    rem_b      = f0 && !first_to_b && free_b;

    // next younger entry that fits the datapath still open
    second = '0;
    f1     = 1'b0;
    seen   = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!f1 && seen && ent_vld[i] && (rem_a ? !ent_int[i] : rem_b)) begin
        f1        = 1'b1;
        second[i] = 1'b1;
      end
      if (first[i]) seen = 1'b1;
    end

    a_sel = first_to_b ? second : first;
    b_sel = first_to_b ? first  : second;
  end

endmodule

// File: rtl/ius_port_busy.sv
module ius_port_busy #(
  parameter int BUSY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  output logic free
);

  localparam int CW = (BUSY > 1) ? $clog2(BUSY) : 1;

  logic [CW-1:0] left;

  assign free = (left == '0);

  always_ff @(posedge clk) begin
    if (rst)               left <= '0;
    else if (take)         left <= CW'(BUSY - 1);
    else if (left != '0)   left <= left - 1'b1;
  end

endmodule

// File: rtl/ius_lat_stub.sv
module ius_lat_stub #(
  parameter int LAT   = 4,
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [TAG_W-1:0] in_tag,
  output logic             out_vld,
  output logic [TAG_W-1:0] out_tag
);

  logic [LAT-1:0]            pv;
  logic [LAT-1:0][TAG_W-1:0] pt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pv <= '0;
      pt <= '0;
    end else begin
      pv[0] <= in_vld;
      pt[0] <= in_tag;
      for (int s = 1; s < LAT; s++) begin
        pv[s] <= pv[s-1];
        pt[s] <= pt[s-1];
      end
    end
  end

  assign out_vld = pv[LAT-1];
  assign out_tag = pt[LAT-1];

endmodule

// File: rtl/dual_issue_unit.sv
module dual_issue_unit
  import ius_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 4,
  parameter int WARP  = 32,
  parameter int LANES = 16,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic             in_int,
  input  logic [TAG_W-1:0] in_tag,
  output logic             in_rdy,
  output logic             iss_a_vld,
  output logic [TAG_W-1:0] iss_a_tag,
  output logic             iss_b_vld,
  output logic             iss_b_int,
  output logic [TAG_W-1:0] iss_b_tag,
  output logic             done_a_vld,
  output logic [TAG_W-1:0] done_a_tag,
  output logic             done_b_vld,
  output logic [TAG_W-1:0] done_b_tag
);

  localparam int BUSY  = occ_cycles(WARP, LANES);
  localparam int NPORT = 2;

  logic [DEPTH-1:0]            ent_vld;
  logic [DEPTH-1:0]            ent_int;
  logic [DEPTH-1:0][TAG_W-1:0] ent_tag;
  logic                        full;
  logic [DEPTH-1:0]            a_sel;
  logic [DEPTH-1:0]            b_sel;
  logic [NPORT-1:0]            take;
  logic [NPORT-1:0]            free;
  logic [TAG_W-1:0]            a_tag_mux;
  logic [TAG_W-1:0]            b_tag_mux;
  logic                        pick_a_int;
  logic                        pick_b_int;
  logic                        pick_a;
  logic                        pick_b;
  logic [NPORT-1:0]            iss_vld;
  logic [NPORT-1:0][TAG_W-1:0] iss_tag;
  logic [NPORT-1:0]            dn_vld;
  logic [NPORT-1:0][TAG_W-1:0] dn_tag;

  ius_ready_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_q (
    .clk      (clk),
    .rst      (rst),
    .push_vld (in_vld),
    .push_int (in_int),
    .push_tag (in_tag),
    .pop_mask (a_sel | b_sel),
    .ent_vld  (ent_vld),
    .ent_int  (ent_int),
    .ent_tag  (ent_tag),
    .full     (full)
  );

  ius_picker #(.DEPTH(DEPTH)) u_pick (
    .ent_vld (ent_vld),
    .ent_int (ent_int),
    .free_a  (free[0]),
    .free_b  (free[1]),
    .a_sel   (a_sel),
    .b_sel   (b_sel)
  );

  assign pick_a  = |a_sel;
  assign pick_b  = |b_sel;
  assign take    = {pick_b, pick_a};
  assign in_rdy  = !full;

  always_comb begin
    a_tag_mux  = '0;
    b_tag_mux  = '0;
    pick_a_int = 1'b0;
    pick_b_int = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      a_tag_mux  = a_tag_mux | (ent_tag[i] & {TAG_W{a_sel[i]}});
      b_tag_mux  = b_tag_mux | (ent_tag[i] & {TAG_W{b_sel[i]}});
      pick_a_int = pick_a_int | (ent_int[i] & a_sel[i]);
      pick_b_int = pick_b_int | (ent_int[i] & b_sel[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld   <= '0;
      iss_tag   <= '0;
      iss_b_int <= 1'b0;
    end else begin
      iss_vld   <= {pick_b, pick_a};
      iss_tag   <= {b_tag_mux, a_tag_mux};
      iss_b_int <= pick_b_int;
    end
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    ius_port_busy #(.BUSY(BUSY)) u_busy (
      .clk  (clk),
      .rst  (rst),
      .take (take[g]),
      .free (free[g])
    );
    ius_lat_stub #(.LAT(LAT), .TAG_W(TAG_W)) u_stub (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (iss_vld[g]),
      .in_tag  (iss_tag[g]),
      .out_vld (dn_vld[g]),
      .out_tag (dn_tag[g])
    );
  end

  assign iss_a_vld  = iss_vld[0];
  assign iss_a_tag  = iss_tag[0];
  assign iss_b_vld  = iss_vld[1];
  assign iss_b_tag  = iss_tag[1];
  assign done_a_vld = dn_vld[0];
  assign done_a_tag = dn_tag[0];
  assign done_b_vld = dn_vld[1];
  assign done_b_tag = dn_tag[1];

endmodule

// File: rtl/dual_issue_unit_chk.sv
module dual_issue_unit_chk (
  input logic clk,
  input logic rst,
  input logic in_rdy,
  input logic iss_a_vld,
  input logic iss_b_vld,
  input logic pick_a,
  input logic pick_b,
  input logic pick_a_int
);

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!iss_a_vld && !iss_b_vld && in_rdy));

  assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (!in_rdy && !pick_a && !pick_b) |=> !in_rdy);

  assert_a_float_only_R3: assert property (@(posedge clk) disable iff (rst)
    pick_a |-> !pick_a_int);

  assert_a_gap_R5: assert property (@(posedge clk) disable iff (rst)
    iss_a_vld |=> !iss_a_vld);

  assert_b_gap_R5: assert property (@(posedge clk) disable iff (rst)
    iss_b_vld |=> !iss_b_vld);

  assert_a_report_R8: assert property (@(posedge clk) disable iff (rst)
    pick_a |=> iss_a_vld);

  assert_b_report_R8: assert property (@(posedge clk) disable iff (rst)
    pick_b |=> iss_b_vld);

endmodule

bind dual_issue_unit dual_issue_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_rdy     (in_rdy),
  .iss_a_vld  (iss_a_vld),
  .iss_b_vld  (iss_b_vld),
  .pick_a     (pick_a),
  .pick_b     (pick_b),
  .pick_a_int (pick_a_int)
);

// File: tb/dual_issue_unit_test.sv
module dual_issue_unit_test;

  localparam int DEPTH = 4;
  localparam int TAG_W = 4;
  localparam int LAT   = 3;
  localparam int BUSY  = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             in_vld = 1'b0;
  logic             in_int = 1'b0;
  logic [TAG_W-1:0] in_tag = '0;
  logic             in_rdy;
  logic             iss_a_vld, iss_b_vld, iss_b_int;
  logic [TAG_W-1:0] iss_a_tag, iss_b_tag;
  logic             done_a_vld, done_b_vld;
  logic [TAG_W-1:0] done_a_tag, done_b_tag;

  always #2 clk = ~clk;

  dual_issue_unit #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WARP(32), .LANES(16), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_int(in_int), .in_tag(in_tag),
    .in_rdy(in_rdy), .iss_a_vld(iss_a_vld), .iss_a_tag(iss_a_tag),
    .iss_b_vld(iss_b_vld), .iss_b_int(iss_b_int), .iss_b_tag(iss_b_tag),
    .done_a_vld(done_a_vld), .done_a_tag(done_a_tag),
    .done_b_vld(done_b_vld), .done_b_tag(done_b_tag)
  );

  typedef struct {bit isint; int tag;} qent_t;
  typedef struct {int port; bit isint; int tag; int cyc;} item_t;

  qent_t mq[$];
  item_t sb[$];
  item_t dq_a[$];
  item_t dq_b[$];
  int    cyc = 0;
  int    ma = 0, mb = 0;
  int    total = 0, bad = 0;
  int    tagc = 0;
  bit    run_mon = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // reference model: predicts issues from the requirements and fills the scoreboard
  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      mq.delete(); ma = 0; mb = 0;
    end else begin
      bit fa, fb, acc;
      int p0, p1, port0;
      qent_t e0, e1;
      fa = (ma == 0); fb = (mb == 0);
      p0 = -1; p1 = -1; port0 = 0;
      for (int i = 0; i < mq.size(); i++)
        if (p0 < 0 && (mq[i].isint ? fb : (fa || fb))) p0 = i;
      if (p0 >= 0) begin
        port0 = (mq[p0].isint || !fa) ? 1 : 0;
        for (int j = p0 + 1; j < mq.size(); j++)
          if (p1 < 0 && ((port0 == 1 && fa && !mq[j].isint) || (port0 == 0 && fb))) p1 = j;
      end
      acc = in_vld && (mq.size() < DEPTH);
      if (ma > 0) ma--;
      if (mb > 0) mb--;
      if (p0 >= 0) begin
        e0 = mq[p0];
        if (port0 == 0) begin
          ma = BUSY - 1;
          sb.push_back('{0, e0.isint, e0.tag, cyc});
          if (p1 >= 0) begin
            e1 = mq[p1]; mb = BUSY - 1;
            sb.push_back('{1, e1.isint, e1.tag, cyc});
          end
        end else begin
          mb = BUSY - 1;
          if (p1 >= 0) begin
            e1 = mq[p1]; ma = BUSY - 1;
            sb.push_back('{0, e1.isint, e1.tag, cyc});
          end
          sb.push_back('{1, e0.isint, e0.tag, cyc});
        end
        if (p1 >= 0) mq.delete(p1);
        mq.delete(p0);
      end
      if (acc) mq.push_back('{in_int, int'(in_tag)});
    end
  end

  // monitor: pops the scoreboard as issues and completions appear
  always @(negedge clk) begin
    if (run_mon && !rst) begin
      item_t it;
      chk(in_rdy == (mq.size() < DEPTH), "R2 in_rdy vs queue occupancy", in_rdy, mq.size() < DEPTH);
      if (iss_a_vld) begin
        if (sb.size() == 0) chk(0, "R5 issue on A with none expected", 1, 0);
        else begin
          it = sb.pop_front();
          chk(it.port == 0, "R3/R7 datapath of issue seen on A", 0, it.port);
          chk(int'(iss_a_tag) == it.tag, "R6/R9 tag on A", iss_a_tag, it.tag);
          chk(it.cyc == cyc, "R8 issue cycle on A", cyc, it.cyc);
          dq_a.push_back('{0, 1'b0, int'(iss_a_tag), cyc + LAT});
        end
      end
      if (iss_b_vld) begin
        if (sb.size() == 0) chk(0, "R5 issue on B with none expected", 1, 0);
        else begin
          it = sb.pop_front();
          chk(it.port == 1, "R4/R7 datapath of issue seen on B", 1, it.port);
          chk(int'(iss_b_tag) == it.tag, "R6/R9 tag on B", iss_b_tag, it.tag);
          chk(iss_b_int == it.isint, "R4 kind on B", iss_b_int, it.isint);
          chk(it.cyc == cyc, "R8 issue cycle on B", cyc, it.cyc);
          dq_b.push_back('{1, 1'b0, int'(iss_b_tag), cyc + LAT});
        end
      end
      while (sb.size() > 0 && sb[0].cyc <= cyc) begin
        it = sb.pop_front();
        chk(0, "R8 expected issue missing", it.tag, it.cyc);
      end
      if (done_a_vld) begin
        if (dq_a.size() == 0) chk(0, "R10 spurious completion on A", 1, 0);
        else begin
          it = dq_a.pop_front();
          chk(int'(done_a_tag) == it.tag, "R10 completion tag on A", done_a_tag, it.tag);
          chk(it.cyc == cyc, "R10 completion cycle on A", cyc, it.cyc);
        end
      end
      if (done_b_vld) begin
        if (dq_b.size() == 0) chk(0, "R10 spurious completion on B", 1, 0);
        else begin
          it = dq_b.pop_front();
          chk(int'(done_b_tag) == it.tag, "R10 completion tag on B", done_b_tag, it.tag);
          chk(it.cyc == cyc, "R10 completion cycle on B", cyc, it.cyc);
        end
      end
    end
  end

  // driver: called at a negedge, returns at the negedge after acceptance
  task automatic push(input bit isint);
    in_vld = 1'b1;
    in_int = isint;
    in_tag = TAG_W'(tagc);
    while (!in_rdy) @(negedge clk);
    @(negedge clk);
    in_vld = 1'b0;
    tagc++;
  endtask

  task automatic idle(input int n);
    in_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    chk(in_rdy == 1'b1, "R1 in_rdy after reset", in_rdy, 1);
    chk(!iss_a_vld && !iss_b_vld, "R1 no issue after reset", iss_a_vld | iss_b_vld, 0);
    chk(!done_a_vld && !done_b_vld, "R1 no completion after reset", done_a_vld | done_b_vld, 0);
    run_mon = 1'b1;

    // float stream: A preferred, both datapaths used (R7, R5)
    for (int i = 0; i < 6; i++) push(1'b0);
    idle(6);
    // integer burst: only B drains, queue fills (R2, R4, R5)
    for (int i = 0; i < 8; i++) push(1'b1);
    idle(10);
    // integer burst then float: younger float overtakes queued integers (R6)
    for (int i = 0; i < 5; i++) push(1'b1);
    push(1'b0);
    push(1'b0);
    idle(12);
    // alternating kinds: integer to B, float to A (R7)
    for (int i = 0; i < 10; i++) push(i[0] == 1'b0);
    idle(8);
    // random kinds and gaps
    for (int i = 0; i < 200; i++) begin
      push($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(20);
    chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
    chk(dq_a.size() == 0 && dq_b.size() == 0, "R10 completions drained",
        dq_a.size() + dq_b.size(), 0);
    chk(mq.size() == 0 && in_rdy, "R2 queue empty at end", in_rdy, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 0);
    summary();
    $finish;
  end

endmodule